// File: doc/BRIEF.md
# Periodic, Alarm and Interrupt Controller

This block is the interrupt half of a real-time clock. A 15-stage divider driven by the oscillator tick produces two things. A rate code picks one of its stages as a tap, and that tap drives both a square-wave pin and a periodic flag. The divider also gives a half-second-aligned seconds pulse that a time counter can use to advance. A three-byte alarm is compared against the current hours, minutes and seconds on every update-ended strobe. An alarm byte whose two top bits are both 1 matches any time value.

Three flags are held in a status byte: periodic, alarm and update-ended. Each flag has its own enable. An active-low interrupt line goes low when any flag and its enable are both set. A status-read strobe clears the flags as they were sampled, but a flag that sets in the same cycle survives the read. The time counter and the bus decoding are outside this block.

Top module: `pai_ctrl`

## Requirements
- R1: Divider control `div_ctl` = 3'b010 advances the 15-bit chain by one on each `osc_tick`. Codes 3'b110 and 3'b111 hold the chain at zero. Every other code freezes the chain at its value.
- R2: The rate code selects the chain bit used as the tap. Code 0 selects no tap. Codes 1 and 2 select bits 6 and 7, which give 256 Hz and 128 Hz from 32.768 kHz. Codes 3 to 15 select bit (code-2), which gives 8192 Hz down to 2 Hz. After the chain is released from zero, the tap bit first rises after 2^bit ticks.
- R3: `sqw` equals the tap level when the square-wave enable is 1, and so has a period of 2^(bit+1) ticks. It is 0 when the enable is 0 or the rate code is 0.
- R4: The periodic flag sets on every rising edge of the tap, whatever the periodic enable holds.
- R5: On an `upd_done` strobe the alarm flag sets if each alarm byte either has bits 7:6 = 2'b11 or equals its time byte. Without the strobe the alarm flag never sets.
- R6: The update-ended flag sets on every `upd_done` strobe.
- R7: `stat_q` is {IRQF, PF, AF, UF, 4'b0000} from bit 7 down to bit 0, where IRQF = (PF&PIE)|(AF&AIE)|(UF&UIE). `irq_n` is 0 exactly when IRQF is 1.
- R8: A `stat_rd` strobe clears PF, AF and UF. A flag whose set condition occurs in the read cycle is 1 afterwards.
- R9: Synchronous reset clears all three flags, all four enables and the chain. It leaves `irq_n` at 1.
- R10: `sec_tick` pulses for one cycle when chain bit 14 rises. This happens 16384 ticks after release from 3'b11x, and every 32768 ticks after that.
- R11: `en_we` loads `en_wdata` into the enables with bit 3 = square-wave enable, bit 2 = PIE, bit 1 = AIE and bit 0 = UIE. `en_q` reads them back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| osc_tick | input | 1 | One-cycle oscillator tick enable |
| div_ctl | input | 3 | Divider run/hold/freeze code |
| rate_sel | input | 4 | Tap rate code |
| en_we | input | 1 | Enable register write strobe |
| en_wdata | input | 4 | Enable write data {sqwe,pie,aie,uie} |
| cur_sec | input | 8 | Current seconds byte |
| cur_min | input | 8 | Current minutes byte |
| cur_hr | input | 8 | Current hours byte |
| alm_sec | input | 8 | Alarm seconds byte |
| alm_min | input | 8 | Alarm minutes byte |
| alm_hr | input | 8 | Alarm hours byte |
| upd_done | input | 1 | One-cycle update-ended strobe |
| stat_rd | input | 1 | One-cycle status read strobe |
| stat_q | output | 8 | Status byte |
| en_q | output | 4 | Enable readback |
| sqw | output | 1 | Square-wave output |
| irq_n | output | 1 | Active-low interrupt request |
| sec_tick | output | 1 | Seconds pulse from the chain |

## Verification
The assertions assume that `osc_tick`, `upd_done` and `stat_rd` are single-cycle strobes sampled on the block clock. They also assume that the time and alarm bytes are stable when `upd_done` is high, and that `rate_sel` only changes while the chain is held or frozen, so that no false tap edge appears. The stimulus respects these rules. It moves the rate code only under code 3'b110 or 3'b000 and drives all strobes for exactly one cycle after a falling edge. Tap timing is measured from a held chain with `osc_tick` high every cycle, so the expected counts are exact powers of two.

// File: rtl/pai_pkg.sv
package pai_pkg;

    localparam int DIV_W  = 15;
    localparam int RATE_W = 4;
    localparam int BYTE_W = 8;
    localparam int N_ALM  = 3;

    typedef struct packed {
        logic sqwe;
        logic pie;
        logic aie;
        logic uie;
    } irq_en_t;

    typedef struct packed {
        logic pf;
        logic af;
        logic uf;
    } irq_flags_t;

    typedef enum logic [1:0] {
        DIV_RUN  = 2'd0,
        DIV_HOLD = 2'd1,
        DIV_STOP = 2'd2
    } div_mode_e;

    function automatic div_mode_e decode_div(input logic [2:0] code);
        if (code[2:1] == 2'b11)  return DIV_HOLD;
        else if (code == 3'b010) return DIV_RUN;
        else                     return DIV_STOP;
    endfunction

    // chain bit observed for a given rate code (code 0 handled separately)
    function automatic logic [3:0] tap_index(input logic [RATE_W-1:0] rs);
        case (rs)
            4'd1:    return 4'd6;
            4'd2:    return 4'd7;
            default: return rs - 4'd2;
        endcase
    endfunction

    function automatic logic alarm_byte_hit(input logic [BYTE_W-1:0] alm,
                                            input logic [BYTE_W-1:0] cur);
        return (alm[BYTE_W-1:BYTE_W-2] == 2'b11) || (alm == cur);
    endfunction

endpackage

// File: rtl/pai_divider.sv
module pai_divider
    import pai_pkg::*;
#(
    parameter int CHAIN_W = DIV_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              osc_tick,
    input  logic [2:0]        div_ctl,
    input  logic [RATE_W-1:0] rate_sel,
    output logic              tap_lvl,
    output logic              tap_rise,
    output logic              sec_tick
);
    localparam int IDX_W = $clog2(CHAIN_W);

    logic [CHAIN_W-1:0] cnt, cnt_next;
    logic [IDX_W-1:0]   tap_idx;
    logic               tap_on;
    logic               sec_q;
    div_mode_e          mode;

    assign mode    = decode_div(div_ctl);
    assign tap_idx = IDX_W'(tap_index(rate_sel));
    assign tap_on  = (rate_sel != '0);

    always_comb begin
        unique case (mode)
            DIV_RUN:  cnt_next = osc_tick ? cnt + CHAIN_W'(1) : cnt;
            DIV_HOLD: cnt_next = '0;
            default:  cnt_next = cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt   <= '0;
            sec_q <= 1'b0;
        end else begin
            cnt   <= cnt_next;
            sec_q <= cnt_next[CHAIN_W-1] & ~cnt[CHAIN_W-1];
        end
    end

    assign tap_lvl  = tap_on & cnt[tap_idx];
    assign tap_rise = tap_on & cnt_next[tap_idx] & ~cnt[tap_idx];
    assign sec_tick = sec_q;

    a_r1_hold_zero: assert property (@(posedge clk) disable iff (rst)
        (div_ctl[2:1] == 2'b11) |=> (cnt == '0));
    a_r1_run_step: assert property (@(posedge clk) disable iff (rst)
        (div_ctl == 3'b010 && osc_tick) |=> (cnt == $past(cnt) + CHAIN_W'(1)));
    a_r1_stop_freeze: assert property (@(posedge clk) disable iff (rst)
        (div_ctl[2:1] != 2'b11 && div_ctl != 3'b010) |=> $stable(cnt));
    a_r10_sec_on_msb: assert property (@(posedge clk) disable iff (rst)
        sec_tick |-> cnt[CHAIN_W-1] && $past(!cnt[CHAIN_W-1]));

endmodule

// File: rtl/pai_alarm.sv
module pai_alarm
    import pai_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst,
    input  logic [N_ALM-1:0][BYTE_W-1:0] cur_time,
    input  logic [N_ALM-1:0][BYTE_W-1:0] alm_time,
    input  logic                        upd,
    output logic                        af_set
);
    logic [N_ALM-1:0] hit;

    for (genvar i = 0; i < N_ALM; i++) begin : g_cmp
        assign hit[i] = alarm_byte_hit(alm_time[i], cur_time[i]);
    end

    assign af_set = upd & (&hit);

    a_r5_all_dc_hits: assert property (@(posedge clk) disable iff (rst)
        (upd && alm_time[0][7:6] == 2'b11 && alm_time[1][7:6] == 2'b11
             && alm_time[2][7:6] == 2'b11) |-> af_set);
    a_r5_needs_strobe: assert property (@(posedge clk) disable iff (rst)
        af_set |-> upd);

endmodule

// File: rtl/pai_status.sv
module pai_status
    import pai_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              en_we,
    input  logic [3:0]        en_wdata,
    input  logic              pf_set,
    input  logic              af_set,
    input  logic              uf_set,
    input  logic              stat_rd,
    output logic [BYTE_W-1:0] stat_byte,
    output logic [3:0]        en_rd,
    output logic              sqwe,
    output logic              irq_n
);
    irq_en_t    en_q;
    irq_flags_t flg_q, flg_d, flg_set;
    logic       irqf;

    assign flg_set = '{pf: pf_set, af: af_set, uf: uf_set};
    assign flg_d   = (flg_q & {3{~stat_rd}}) | flg_set;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q  <= '0;
            flg_q <= '0;
        end else begin
            if (en_we) en_q <= irq_en_t'(en_wdata);
            flg_q <= flg_d;
        end
    end

    assign irqf = (flg_q.pf & en_q.pie) | (flg_q.af & en_q.aie) | (flg_q.uf & en_q.uie);

    assign stat_byte = {irqf, flg_q.pf, flg_q.af, flg_q.uf, 4'b0000};
    assign en_rd     = en_q;
    assign sqwe      = en_q.sqwe;
    assign irq_n     = ~irqf;

    a_r8_read_clears: assert property (@(posedge clk) disable iff (rst)
        (stat_rd && !uf_set) |=> !flg_q.uf);
    a_r8_set_survives: assert property (@(posedge clk) disable iff (rst)
        uf_set |=> flg_q.uf);
    a_r4_pf_from_tap: assert property (@(posedge clk) disable iff (rst)
        pf_set |=> stat_byte[6]);
    a_r5_af_origin: assert property (@(posedge clk) disable iff (rst)
        $rose(flg_q.af) |-> $past(af_set));
    a_r7_irq_needs_en: assert property (@(posedge clk) disable iff (rst)
        !irq_n |-> (en_q.pie || en_q.aie || en_q.uie));
    a_r9_reset_clear: assert property (@(posedge clk)
        rst |=> (en_q == '0 && flg_q == '0 && irq_n));

endmodule

// File: rtl/pai_ctrl.sv
module pai_ctrl
    import pai_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              osc_tick,
    input  logic [2:0]        div_ctl,
    input  logic [RATE_W-1:0] rate_sel,
    input  logic              en_we,
    input  logic [3:0]        en_wdata,
    input  logic [BYTE_W-1:0] cur_sec,
    input  logic [BYTE_W-1:0] cur_min,
    input  logic [BYTE_W-1:0] cur_hr,
    input  logic [BYTE_W-1:0] alm_sec,
    input  logic [BYTE_W-1:0] alm_min,
    input  logic [BYTE_W-1:0] alm_hr,
    input  logic              upd_done,
    input  logic              stat_rd,
    output logic [BYTE_W-1:0] stat_q,
    output logic [3:0]        en_q,
    output logic              sqw,
    output logic              irq_n,
    output logic              sec_tick
);
    logic tap_lvl, tap_rise, af_set, sqwe;

    pai_divider #(.CHAIN_W(DIV_W)) u_div (
        .clk      (clk),
        .rst      (rst),
        .osc_tick (osc_tick),
        .div_ctl  (div_ctl),
        .rate_sel (rate_sel),
        .tap_lvl  (tap_lvl),
        .tap_rise (tap_rise),
        .sec_tick (sec_tick)
    );

    pai_alarm u_alm (
        .clk      (clk),
        .rst      (rst),
        .cur_time ({cur_hr, cur_min, cur_sec}),
        .alm_time ({alm_hr, alm_min, alm_sec}),
        .upd      (upd_done),
        .af_set   (af_set)
    );

    pai_status u_stat (
        .clk       (clk),
        .rst       (rst),
        .en_we     (en_we),
        .en_wdata  (en_wdata),
        .pf_set    (tap_rise),
        .af_set    (af_set),
        .uf_set    (upd_done),
        .stat_rd   (stat_rd),
        .stat_byte (stat_q),
        .en_rd     (en_q),
        .sqwe      (sqwe),
        .irq_n     (irq_n)
    );

    assign sqw = sqwe & tap_lvl;

    a_r3_sqw_gated: assert property (@(posedge clk) disable iff (rst)
        !en_q[3] |-> !sqw);

endmodule

// File: tb/pai_ctrl_tb.sv
module pai_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       osc_tick = 1'b0;
    logic [2:0] div_ctl = 3'b110;
    logic [3:0] rate_sel = 4'd0;
    logic       en_we = 1'b0;
    logic [3:0] en_wdata = 4'd0;
    logic [7:0] cur_sec = 8'h25, cur_min = 8'h17, cur_hr = 8'h09;
    logic [7:0] alm_sec = 8'h00, alm_min = 8'h00, alm_hr = 8'h00;
    logic       upd_done = 1'b0;
    logic       stat_rd = 1'b0;
    logic [7:0] stat_q;
    logic [3:0] en_q;
    logic       sqw, irq_n, sec_tick;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    pai_ctrl dut_i (
        .clk(clk), .rst(rst), .osc_tick(osc_tick), .div_ctl(div_ctl),
        .rate_sel(rate_sel), .en_we(en_we), .en_wdata(en_wdata),
        .cur_sec(cur_sec), .cur_min(cur_min), .cur_hr(cur_hr),
        .alm_sec(alm_sec), .alm_min(alm_min), .alm_hr(alm_hr),
        .upd_done(upd_done), .stat_rd(stat_rd), .stat_q(stat_q),
        .en_q(en_q), .sqw(sqw), .irq_n(irq_n), .sec_tick(sec_tick)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic write_en(input logic [3:0] v);
        en_we = 1'b1; en_wdata = v; step(); en_we = 1'b0;
    endtask

    task automatic read_stat();
        stat_rd = 1'b1; step(); stat_rd = 1'b0;
    endtask

    task automatic pulse_upd();
        upd_done = 1'b1; step(); upd_done = 1'b0;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        osc_tick = 1'b1;
        step(); step();
        rst = 1'b0;
        step();
        // R9 reset state
        chk("R9 stat", stat_q, 0);
        chk("R9 en", en_q, 0);
        chk("R9 irq_n", irq_n, 1);
        chk("R3 sqw after reset", sqw, 0);

        // R11 enable write and readback
        write_en(4'b1010);
        chk("R11 en readback", en_q, 4'b1010);

        // R2 R3 R4 rate sweep, sqwe=1, pie=0
        write_en(4'b1000);
        for (int rs = 1; rs < 16; rs++) begin
            int idx, m;
            idx = (rs < 3) ? rs + 5 : rs - 2;
            div_ctl = 3'b110; rate_sel = rs[3:0];
            stat_rd = 1'b1; step(); stat_rd = 1'b0;
            div_ctl = 3'b010;
            m = 0;
            do begin step(); m++; end while (!sqw && m < 20000);
            chk($sformatf("R2 first rise code %0d", rs), m, 1 << idx);
            chk($sformatf("R4 pf code %0d", rs), stat_q[6], 1);
            chk($sformatf("R7 irq_n pie=0 code %0d", rs), irq_n, 1);
            m = 0;
            do begin step(); m++; end while (sqw && m < 20000);
            do begin step(); m++; end while (!sqw && m < 40000);
            chk($sformatf("R3 period code %0d", rs), m, 1 << (idx + 1));
        end

        // R2 code 0: no tap, no PF
        div_ctl = 3'b110; rate_sel = 4'd0; step();
        read_stat();
        div_ctl = 3'b010;
        begin
            int hi = 0;
            for (int i = 0; i < 100; i++) begin step(); hi += sqw; end
            chk("R2 code0 sqw", hi, 0);
        end
        chk("R2 code0 pf", stat_q[6], 0);

        // R3 sqwe=0 holds sqw low, R4 PF still sets
        div_ctl = 3'b110; rate_sel = 4'd3; write_en(4'b0000);
        read_stat();
        div_ctl = 3'b010;
        begin
            int hi = 0;
            for (int i = 0; i < 10; i++) begin step(); hi += sqw; end
            chk("R3 sqwe0 sqw", hi, 0);
        end
        chk("R4 pf with sqwe0 pie0", stat_q[6], 1);

        // R1 hold: chain pinned at zero
        write_en(4'b1000);
        div_ctl = 3'b111; step(); read_stat();
        begin
            int hi = 0;
            for (int i = 0; i < 20; i++) begin step(); hi += sqw; end
            chk("R1 hold sqw", hi, 0);
        end
        chk("R1 hold pf", stat_q[6], 0);

        // R1 freeze: count 3, stop, level stays
        div_ctl = 3'b110; step();
        div_ctl = 3'b010; step(); step(); step();
        chk("R1 run count3 sqw", sqw, 1);
        div_ctl = 3'b000;
        begin
            int hi = 0;
            for (int i = 0; i < 20; i++) begin step(); hi += sqw; end
            chk("R1 freeze sqw", hi, 20);
        end
        div_ctl = 3'b010; step();
        chk("R1 resume count4 sqw", sqw, 0);

        // R10 seconds pulse
        div_ctl = 3'b110; step();
        div_ctl = 3'b010;
        begin
            int m = 0;
            do begin step(); m++; end while (!sec_tick && m < 40000);
            chk("R10 first sec_tick", m, 16384);
            m = 0;
            do begin step(); m++; end while (!sec_tick && m < 40000);
            chk("R10 sec_tick period", m, 32768);
        end

        div_ctl = 3'b000; rate_sel = 4'd0; write_en(4'b0000);
        read_stat();

        // R5 R6 alarm don't-care / mismatch sweep
        for (int dc = 0; dc < 8; dc++) begin
            for (int mis = 0; mis < 8; mis++) begin
                logic [7:0] fill;
                int exp;
                fill = 8'hC0 | 8'((dc << 3) | mis);
                alm_sec = dc[0] ? fill : (mis[0] ? cur_sec ^ 8'h01 : cur_sec);
                alm_min = dc[1] ? fill : (mis[1] ? cur_min ^ 8'h02 : cur_min);
                alm_hr  = dc[2] ? fill : (mis[2] ? cur_hr  ^ 8'h04 : cur_hr);
                exp = ((dc[0] || !mis[0]) && (dc[1] || !mis[1]) && (dc[2] || !mis[2])) ? 1 : 0;
                read_stat();
                pulse_upd();
                chk($sformatf("R5 af dc=%0d mis=%0d", dc, mis), stat_q[5], exp);
                chk($sformatf("R6 uf dc=%0d mis=%0d", dc, mis), stat_q[4], 1);
            end
        end
        // R5 seconds sweep, hours and minutes don't-care
        alm_sec = 8'd48; alm_min = 8'hFF; alm_hr = 8'hC3;
        for (int s = 0; s < 60; s++) begin
            cur_sec = s[7:0];
            read_stat();
            pulse_upd();
            chk($sformatf("R5 sec sweep %0d", s), stat_q[5], (s == 48) ? 1 : 0);
        end
        // R5 no strobe, no alarm
        cur_sec = 8'd48;
        read_stat();
        step(); step();
        chk("R5 no strobe af", stat_q[5], 0);
        chk("R6 no strobe uf", stat_q[4], 0);

        // R7 IRQF and irq_n across enables and flag patterns
        rate_sel = 4'd3;
        for (int en = 0; en < 8; en++) begin
            for (int pf = 0; pf < 2; pf++) begin
                for (int fu = 0; fu < 3; fu++) begin
                    int af, uf, irqf;
                    af = (fu == 2) ? 1 : 0;
                    uf = (fu != 0) ? 1 : 0;
                    write_en(en[3:0]);
                    read_stat();
                    if (pf == 1) begin
                        div_ctl = 3'b110; step();
                        div_ctl = 3'b010; step(); step();
                        div_ctl = 3'b000;
                    end
                    if (fu != 0) begin
                        alm_sec = (af == 1) ? cur_sec : cur_sec ^ 8'h10;
                        pulse_upd();
                    end
                    irqf = (pf & en[2]) | (af & en[1]) | (uf & en[0]);
                    chk($sformatf("R7 stat en=%0d pf=%0d af=%0d uf=%0d", en, pf, af, uf),
                        stat_q, (irqf << 7) | (pf << 6) | (af << 5) | (uf << 4));
                    chk($sformatf("R7 irq_n en=%0d pf=%0d af=%0d uf=%0d", en, pf, af, uf),
                        irq_n, irqf ? 0 : 1);
                end
            end
        end

        // R8 read with concurrent set
        alm_sec = cur_sec; read_stat(); pulse_upd();
        chk("R8 setup af uf", stat_q[5:4], 3);
        alm_sec = cur_sec ^ 8'h10;
        stat_rd = 1'b1; upd_done = 1'b1; step(); stat_rd = 1'b0; upd_done = 1'b0;
        chk("R8 uf survives read", stat_q[4], 1);
        chk("R8 af cleared by read", stat_q[5], 0);
        read_stat();
        chk("R8 read clears all", stat_q, 0);

        // R9 reset mid-run
        write_en(4'b1111);
        alm_sec = cur_sec; pulse_upd();
        chk("R9 pre-reset irq_n", irq_n, 0);
        rst = 1'b1; step(); rst = 1'b0;
        chk("R9 reset en", en_q, 0);
        chk("R9 reset stat", stat_q, 0);
        chk("R9 reset irq_n", irq_n, 1);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule